// File: doc/BRIEF.md
# Multi-CPU Interrupt Source Controller

This block gathers a parameterised set of level-sensitive interrupt lines and hands each of them to one or more of up to four processors. Software programs it through a single-beat register port with a 32-bit data path. A view-select input chooses between the shared (global) register window and a per-processor window, and a processor-index input tells the block which processor is making the access. In the per-processor window, the index picks whose mask set is changed and whose acknowledge value is returned.

Software never rewrites whole bit vectors. To turn a source on or off, it writes the source number to a set register or to a clear register. This applies both to the global enable and to each processor's mask. A source reaches a processor only when four things hold: its line is high, it is globally enabled, its routing word names that processor, and that processor has unmasked it. A small set of per-processor sources skips the routing word. When several sources qualify, the lowest number wins. IDs 0 and 1 are kept for doorbell summary lines that are wired in like any other source. The value 1023 in the acknowledge field means that nothing is pending. Each processor also gets a level interrupt output that follows its own acknowledge value.

Top module: `mic_top`

## Requirements
- R1: After reset every global enable is 0, every routing word is 0, every per-processor mask bit is 1 (masked), every `cpu_irq` bit is 0, and every acknowledge read returns 1023.
- R2: In the global view (`bus_percpu`=0), a write to offset 0x030 sets the global enable of the source whose number is in `bus_wdata[9:0]`. A write to offset 0x034 clears it.
- R3: In the per-processor view (`bus_percpu`=1), a write to offset 0x048 masks source `bus_wdata[9:0]` for processor `bus_cpu` only. A write to offset 0x04C unmasks it. The masks of the other processors do not change.
- R4: A global-view read of offset 0x000 returns the number of implemented sources in bits [11:2], with all other bits 0.
- R5: Source n has a routing word at global offset 0x100 + 4*n. Bits [NUM_CPU-1:0] of the written data are stored as a target-processor mask. A read returns those bits, with all other bits 0.
- R6: A shared source reaches processor c only when all of these hold: its line is high, it is globally enabled, bit c of its routing word is set, and processor c has it unmasked.
- R7: A per-processor-view read of offset 0x044 returns, in bits [9:0], the lowest-numbered source pending for processor `bus_cpu`. It returns 1023 when no source is pending. Bits [31:10] read 0.
- R8: Sources 3 and 5 are per-processor sources. They ignore the routing word and reach every processor that has them unmasked, provided they are globally enabled and their line is high.
- R9: `cpu_irq[c]` is high in exactly the cycles in which processor c's acknowledge value is below 1023. It follows the source lines combinationally.
- R10: A set or clear write, to enables or to masks, that carries a source number of NUM_SRC or more changes no state. A write to a routing-word offset at or beyond source NUM_SRC also changes no state.
- R11: A read gives `bus_rvalid`=1 with `bus_rdata` in the cycle after it is accepted. A write gives no `bus_rvalid`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NUM_SRC | Level-sensitive source lines; bit n is source ID n |
| bus_valid | input | 1 | Register access request, one beat |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_percpu | input | 1 | View select: 0 = global window, 1 = per-processor window |
| bus_cpu | input | CPU_W | Index of the accessing processor |
| bus_addr | input | 12 | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| bus_rdata | output | 32 | Read data |
| cpu_irq | output | NUM_CPU | Level interrupt output to each processor |

## Verification
On every cycle, the assertions check the effects of the set/clear commands. An in-range command must land on the named enable bit. An out-of-range one must leave the enables untouched. A mask write must leave the other processors' masks untouched. They also check that an asserted `cpu_irq` always has a live, enabled, unmasked source behind it, and the one-cycle read-response timing. Only the bench's scenarios can show the rest. That covers lowest-ID arbitration as lines rise and fall, per-processor sources bypassing routing, routing words read back and truncated to the processor mask, and out-of-range indices that alias onto real sources under a narrow decoder.

// File: rtl/mic_pkg.sv
package mic_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 10;

  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

  // Global window
  localparam logic [ADDR_W-1:0] OFS_CTRL       = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_SET     = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR     = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_ROUTE_BASE = 12'h100;
  // Per-processor window
  localparam logic [ADDR_W-1:0] OFS_ACK        = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_MSK_SET    = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_MSK_CLR    = 12'h04C;
endpackage

// File: rtl/mic_src_regs.sv
module mic_src_regs
  import mic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en_set,
  input  logic                             en_clr,
  input  logic [ID_W-1:0]                  idx,
  input  logic                             route_we,
  input  logic [ID_W-1:0]                  route_idx,
  input  logic [NUM_CPU-1:0]               route_wdata,
  output logic [NUM_SRC-1:0]               glob_en,
  output logic [NUM_SRC-1:0][NUM_CPU-1:0]  route_q
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]              en_d;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_d;
  logic                            idx_ok;
  logic                            ridx_ok;
  logic                            en_ce;
  logic                            route_ce;

  assign idx_ok   = (int'(idx) < NUM_SRC);
  assign ridx_ok  = (int'(route_idx) < NUM_SRC);
  assign en_ce    = (en_set | en_clr) & idx_ok;
  assign route_ce = route_we & ridx_ok;

  always_comb begin
    en_d = glob_en;
    if (en_set) begin
      en_d[idx[SRC_W-1:0]] = 1'b1;
    end else if (en_clr) begin
      en_d[idx[SRC_W-1:0]] = 1'b0;
    end
  end

  always_comb begin
    route_d = route_q;
    route_d[route_idx[SRC_W-1:0]] = route_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en <= '0;
    end else if (en_ce) begin
      glob_en <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
    end else if (route_ce) begin
      route_q <= route_d;
    end
  end
endmodule

// File: rtl/mic_cpu_mask.sv
module mic_cpu_mask
  import mic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msk_set,
  input  logic               msk_clr,
  input  logic [ID_W-1:0]    idx,
  output logic [NUM_SRC-1:0] mask_q
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] mask_d;
  logic               mask_ce;

  assign mask_ce = (msk_set | msk_clr) & (int'(idx) < NUM_SRC);

  always_comb begin
    mask_d = mask_q;
    if (msk_set) begin
      mask_d[idx[SRC_W-1:0]] = 1'b1;
    end else if (msk_clr) begin
      mask_d[idx[SRC_W-1:0]] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/mic_prio_enc.sv
module mic_prio_enc
  import mic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] req,
  output logic [ID_W-1:0]    id,
  output logic               any
);
  always_comb begin
    id  = ID_NONE;
    any = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        id  = ID_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mic_top.sv
module mic_top
  import mic_pkg::*;
#(
  parameter int                 NUM_SRC    = 32,
  parameter int                 NUM_CPU    = 4,
  parameter logic [NUM_SRC-1:0] PERCPU_MAP = NUM_SRC'(32'h0000_0028),
  localparam int                CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic               bus_percpu,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic               bus_rvalid,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CPU-1:0] cpu_irq
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // Access decode
  logic              wr_acc;
  logic              rd_acc;
  logic [ID_W-1:0]   wr_idx;
  logic              en_set;
  logic              en_clr;
  logic              msk_set;
  logic              msk_clr;
  logic              cpu_ok;
  logic [ADDR_W-1:0] route_off;
  logic [ID_W-1:0]   route_idx;
  logic              route_in_win;
  logic              route_we;
  logic              route_rd_hit;

  assign wr_acc  = bus_valid & bus_write;
  assign rd_acc  = bus_valid & ~bus_write;
  assign wr_idx  = bus_wdata[ID_W-1:0];
  assign cpu_ok  = (int'(bus_cpu) < NUM_CPU);

  assign en_set  = wr_acc & ~bus_percpu & (bus_addr == OFS_EN_SET);
  assign en_clr  = wr_acc & ~bus_percpu & (bus_addr == OFS_EN_CLR);
  assign msk_set = wr_acc &  bus_percpu & cpu_ok & (bus_addr == OFS_MSK_SET);
  assign msk_clr = wr_acc &  bus_percpu & cpu_ok & (bus_addr == OFS_MSK_CLR);

  assign route_off    = bus_addr - OFS_ROUTE_BASE;
  assign route_idx    = route_off[ADDR_W-1:2];
  assign route_in_win = ~bus_percpu & (bus_addr >= OFS_ROUTE_BASE)
                      & (bus_addr[1:0] == 2'b00);
  assign route_we     = wr_acc & route_in_win;
  assign route_rd_hit = route_in_win & (int'(route_idx) < NUM_SRC);

  // Per-source state
  logic [NUM_SRC-1:0]              glob_en;
  logic [NUM_SRC-1:0][NUM_CPU-1:0] route_q;

  mic_src_regs #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU)
  ) u_src_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .en_set      (en_set),
    .en_clr      (en_clr),
    .idx         (wr_idx),
    .route_we    (route_we),
    .route_idx   (route_idx),
    .route_wdata (bus_wdata[NUM_CPU-1:0]),
    .glob_en     (glob_en),
    .route_q     (route_q)
  );

  // Per-processor masks, qualification and arbitration
  logic [NUM_CPU-1:0][NUM_SRC-1:0] cpu_mask;
  logic [NUM_CPU-1:0][NUM_SRC-1:0] cpu_req;
  logic [NUM_CPU-1:0][ID_W-1:0]    ack_id;
  logic [NUM_CPU-1:0]              ack_any;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic this_cpu;
    assign this_cpu = (bus_cpu == CPU_W'(c));

    mic_cpu_mask #(
      .NUM_SRC (NUM_SRC)
    ) u_mask (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .msk_set (msk_set & this_cpu),
      .msk_clr (msk_clr & this_cpu),
      .idx     (wr_idx),
      .mask_q  (cpu_mask[c])
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (PERCPU_MAP[s]) begin : g_local
        assign cpu_req[c][s] = src_level[s] & glob_en[s] & ~cpu_mask[c][s];
      end else begin : g_shared
        assign cpu_req[c][s] = src_level[s] & glob_en[s] & ~cpu_mask[c][s]
                             & route_q[s][c];
      end
    end

    mic_prio_enc #(
      .NUM_SRC (NUM_SRC)
    ) u_enc (
      .req (cpu_req[c]),
      .id  (ack_id[c]),
      .any (ack_any[c])
    );

    assign cpu_irq[c] = ack_any[c];
  end

  // Read path, one registered beat
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (!bus_percpu) begin
      if (bus_addr == OFS_CTRL) begin
        rd_d[11:2] = 10'(NUM_SRC);
      end else if (route_rd_hit) begin
        rd_d[NUM_CPU-1:0] = route_q[route_idx[SRC_W-1:0]];
      end
    end else if ((bus_addr == OFS_ACK) && cpu_ok) begin
      rd_d[ID_W-1:0] = ack_id[bus_cpu];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_acc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_rdata <= '0;
    end else if (rd_acc) begin
      bus_rdata <= rd_d;
    end
  end
endmodule

// File: rtl/mic_chk.sv
module mic_chk
  import mic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_SRC-1:0]              src_level,
  input logic                            bus_valid,
  input logic                            bus_write,
  input logic                            bus_percpu,
  input logic [CPU_W-1:0]                bus_cpu,
  input logic [11:0]                     bus_addr,
  input logic [31:0]                     bus_wdata,
  input logic                            bus_rvalid,
  input logic [NUM_CPU-1:0]              cpu_irq,
  input logic [NUM_SRC-1:0]              glob_en,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] cpu_mask
);
  logic gw_set;
  logic gw_clr;
  logic pw_msk;
  logic idx_big;

  assign gw_set  = bus_valid & bus_write & ~bus_percpu & (bus_addr == OFS_EN_SET);
  assign gw_clr  = bus_valid & bus_write & ~bus_percpu & (bus_addr == OFS_EN_CLR);
  assign pw_msk  = bus_valid & bus_write & bus_percpu
                 & ((bus_addr == OFS_MSK_SET) | (bus_addr == OFS_MSK_CLR));
  assign idx_big = (int'(bus_wdata[ID_W-1:0]) >= NUM_SRC);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
    // R2: set command lands on the named enable
    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gw_set && bus_wdata[ID_W-1:0] == ID_W'(s)) |=> glob_en[s]);
    // R2: clear command drops the named enable
    p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gw_clr && bus_wdata[ID_W-1:0] == ID_W'(s)) |=> !glob_en[s]);
  end

  // R10: out-of-range numbers leave the enables alone
  p_en_oob_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((gw_set || gw_clr) && idx_big) |=> $stable(glob_en));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    // R3: another processor's mask command leaves this mask alone
    p_mask_iso_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_msk && bus_cpu != CPU_W'(c)) |=> $stable(cpu_mask[c]));
    // R10: out-of-range mask commands change nothing
    p_mask_oob_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_msk && idx_big) |=> $stable(cpu_mask[c]));
    // R6: an interrupt needs a live, enabled, unmasked source
    p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[c] |-> ((src_level & glob_en & ~cpu_mask[c]) != '0));
  end

  // R11: read answered one cycle later, nothing else answered
  p_rd_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);
  p_no_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
endmodule

bind mic_top mic_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_CPU (NUM_CPU),
  .CPU_W   (CPU_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .src_level  (src_level),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_percpu (bus_percpu),
  .bus_cpu    (bus_cpu),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .cpu_irq    (cpu_irq),
  .glob_en    (glob_en),
  .cpu_mask   (cpu_mask)
);

// File: tb/mic_top_tb.sv
module mic_top_tb;
  localparam int CLK_P = 10;
  localparam int NS    = 32;
  localparam int NC    = 4;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] src_level;
  logic          bus_valid;
  logic          bus_write;
  logic          bus_percpu;
  logic [1:0]    bus_cpu;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata;
  logic          bus_rvalid;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] cpu_irq;

  mic_top u_dut (
    .clk(clk), .rst_n(rst_n), .src_level(src_level),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_percpu(bus_percpu),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_chk;
  int n_fail;
  bit cmp_on;
  bit done;

  // Reference state
  bit m_en   [NS];
  bit m_mask [NC][NS];
  int m_route[NS];

  function automatic bit is_local(int s);
    return (s == 3) || (s == 5);
  endfunction

  function automatic int m_ack(int c);
    for (int s = 0; s < NS; s++) begin
      if (src_level[s] && m_en[s] && !m_mask[c][s] &&
          (is_local(s) || m_route[s][c]))
        return s;
    end
    return 1023;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(bit pc, int cpu, int addr, int data);
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 1; bus_percpu = pc;
    bus_cpu = 2'(cpu); bus_addr = 12'(addr); bus_wdata = data;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
    if (!pc) begin
      if (addr == 'h30 && (data & 'h3FF) < NS) m_en[data & 'h3FF] = 1;
      if (addr == 'h34 && (data & 'h3FF) < NS) m_en[data & 'h3FF] = 0;
      if (addr >= 'h100 && addr % 4 == 0 && (addr - 'h100) / 4 < NS)
        m_route[(addr - 'h100) / 4] = data & 'hF;
    end else begin
      if (addr == 'h48 && (data & 'h3FF) < NS) m_mask[cpu][data & 'h3FF] = 1;
      if (addr == 'h4C && (data & 'h3FF) < NS) m_mask[cpu][data & 'h3FF] = 0;
    end
  endtask

  task automatic bus_rd(bit pc, int cpu, int addr, int exp, string tag);
    @(negedge clk); #1;
    bus_valid = 1; bus_write = 0; bus_percpu = pc;
    bus_cpu = 2'(cpu); bus_addr = 12'(addr);
    @(posedge clk); #1;
    bus_valid = 0;
    @(negedge clk);
    chk(bus_rvalid == 1'b1, "R11 rvalid", int'(bus_rvalid), 1);
    chk(bus_rdata == 32'(exp), tag, int'(bus_rdata), exp);
  endtask

  task automatic set_src(int s, bit v);
    @(negedge clk); #1;
    src_level[s] = v;
  endtask

  task automatic rd_ack(int c, string tag);
    bus_rd(1, c, 'h44, m_ack(c), tag);
  endtask

  // Every-cycle comparison of interrupt outputs
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      for (int c = 0; c < NC; c++) begin
        bit e;
        e = (m_ack(c) != 1023);
        chk(cpu_irq[c] == e, "R9 R6 cpu_irq", int'(cpu_irq[c]), int'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; cmp_on = 0; done = 0;
    for (int s = 0; s < NS; s++) begin
      m_en[s] = 0; m_route[s] = 0;
      for (int c = 0; c < NC; c++) m_mask[c][s] = 1;
    end
    src_level = '0; bus_valid = 0; bus_write = 0; bus_percpu = 0;
    bus_cpu = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1: reset state
    chk(cpu_irq == '0, "R1 cpu_irq", int'(cpu_irq), 0);
    for (int c = 0; c < NC; c++) bus_rd(1, c, 'h44, 1023, "R1 ack");
    bus_rd(0, 0, 'h100 + 4*4, 0, "R1 route");
    // R4: control register
    bus_rd(0, 0, 'h000, NS << 2, "R4 ctrl");

    // R5: routing word stored and truncated
    src_level[4] = 1;
    bus_wr(0, 0, 'h100 + 4*4, 32'hFFFF_FF12);
    bus_rd(0, 0, 'h100 + 4*4, 2, "R5 route");
    bus_wr(0, 0, 'h30, 4);
    // R3: still masked on processor 1
    rd_ack(1, "R3 masked");
    bus_wr(1, 1, 'h4C, 4);
    @(negedge clk);
    chk(bus_rvalid == 0, "R11 no rvalid on write", int'(bus_rvalid), 0);
    rd_ack(1, "R6 delivered");
    rd_ack(0, "R6 not routed");

    // R7: lowest ID wins
    bus_wr(0, 0, 'h100 + 4*9, 2);
    bus_wr(0, 0, 'h30, 9);
    bus_wr(1, 1, 'h4C, 9);
    set_src(9, 1);
    rd_ack(1, "R7 lowest");
    set_src(4, 0);
    rd_ack(1, "R7 next");
    // R3: processor 2 masking does not touch processor 1
    bus_wr(1, 2, 'h4C, 9);
    bus_wr(1, 2, 'h48, 9);
    rd_ack(1, "R3 isolation");
    bus_wr(1, 1, 'h48, 9);
    rd_ack(1, "R3 mask set");
    bus_wr(1, 1, 'h4C, 9);
    // R2: clear enable
    bus_wr(0, 0, 'h34, 9);
    rd_ack(1, "R2 clear");

    // R8: per-processor source ignores routing
    set_src(5, 1);
    bus_wr(0, 0, 'h30, 5);
    bus_wr(1, 0, 'h4C, 5);
    bus_wr(1, 3, 'h4C, 5);
    rd_ack(0, "R8 cpu0");
    rd_ack(3, "R8 cpu3");
    rd_ack(1, "R8 cpu1 masked");
    set_src(5, 0);

    // R6: shared source with zero routing reaches nobody
    set_src(6, 1);
    bus_wr(0, 0, 'h30, 6);
    for (int c = 0; c < NC; c++) bus_wr(1, c, 'h4C, 6);
    for (int c = 0; c < NC; c++) rd_ack(c, "R6 unrouted");

    // R10: out-of-range indices must not alias
    set_src(7, 1);
    bus_wr(0, 0, 'h100 + 4*7, 1);
    bus_wr(1, 0, 'h4C, 7);
    bus_wr(0, 0, 'h30, NS + 7);
    rd_ack(0, "R10 enable alias");
    bus_wr(0, 0, 'h30, 7);
    bus_wr(1, 0, 'h48, NS + 7);
    rd_ack(0, "R10 mask alias");
    bus_wr(0, 0, 'h100 + 4*NS, 'hF);
    bus_rd(0, 0, 'h100 + 4*NS, 0, "R10 route beyond");
    bus_rd(0, 0, 'h100, 0, "R10 route alias");
    bus_wr(0, 0, 'h34, 'h3FF);
    rd_ack(0, "R10 clear alias");

    // R11: unmapped offset reads 0
    bus_rd(0, 0, 'h020, 0, "R11 unmapped");
    bus_rd(1, 2, 'h040, 0, "R11 unmapped cpu");

    // R9: output drops as lines fall
    set_src(6, 0);
    set_src(7, 0);
    set_src(9, 0);
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) rd_ack(c, "R9 idle");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule